// File: doc/BRIEF.md
# Linked-List Frame Buffer DMA Sequencer

This block chooses the memory destination of every captured video frame. Destinations come from a ring of descriptors held in system memory. Each descriptor is two 32-bit words: a frame buffer base address, then the address of the following descriptor. On enable the sequencer reads the descriptor at the pointer held in the first-descriptor register. It then waits for a frame start and issues fixed-length write bursts through that frame. A burst is started whenever the pixel FIFO signals that its threshold is reached. The burst addresses run upward from the buffer base.

When the frame ends, the sequencer follows the link word and fetches the next descriptor. A link that points back to an earlier descriptor closes the ring, so frames rotate through two, three or more buffers with no software help. The transfer width is 32 bits, so each burst advances the write address by four bytes per beat.

Top module: `fbd_dma_seq`

## Requirements
- R1: While rst_ni is low and after its release with en_i low, rd_req_o and burst_req_o are 0.
- R2: One cycle after en_i is sampled high in idle, rd_req_o is 1 with rd_addr_o equal to first_desc_i. The base word at that address is read first, then the link word at that address plus 4.
- R3: Within a frame the first burst address equals the descriptor base word. Each later burst is BURST_BEATS*4 bytes above the previous one.
- R4: burst_req_o rises one cycle after fifo_thr_i is sampled high during a frame while no burst is pending. It stays high until burst_done_i is sampled, and it is low in the following cycle.
- R5: Outside a frame (before frame_start_i is accepted, or while a descriptor is being fetched), fifo_thr_i has no effect and burst_req_o stays 0.
- R6: After a frame ends, the descriptor at the previous link word is fetched (base word, then link word). A link back to an earlier descriptor repeats that descriptor's buffer, forming a ping-pong or triple-buffer ring.
- R7: A frame_start_i pulse that arrives while a descriptor fetch is pending is held. The frame begins as soon as the fetch completes, with no further start pulse.
- R8: A frame_end_i pulse during a pending burst does not cut that burst. The next descriptor fetch starts three cycles after burst_done_i is sampled.
- R9: Clearing en_i lets a pending burst finish, after which the block is idle and ignores fifo_thr_i. Setting en_i again restarts the chain at the current first_desc_i.
- R10: rd_req_o, once raised, holds with a stable rd_addr_o until rd_valid_i is sampled. rd_req_o and burst_req_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sequencer enable |
| first_desc_i | input | ADDR_W | Address of the first descriptor in the ring |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | ADDR_W | Descriptor word address |
| rd_valid_i | input | 1 | Read data valid, one-cycle pulse |
| rd_data_i | input | ADDR_W | Read data word |
| frame_start_i | input | 1 | Frame start strobe |
| frame_end_i | input | 1 | Frame end strobe |
| fifo_thr_i | input | 1 | FIFO fill has reached the burst threshold |
| burst_req_o | output | 1 | Write burst request, held until done |
| burst_addr_o | output | ADDR_W | Start address of the requested burst |
| burst_done_i | input | 1 | Burst completed |

## Verification
Inputs are driven on the falling edge and outputs are sampled on a later falling edge. A result that follows one register is therefore checked at the very next falling edge. burst_req_o and the first rd_req_o are both checked one falling edge after their trigger. After burst_done_i, burst_req_o is checked one edge later. When a frame ends during a burst, the new fetch address is checked exactly three edges after burst_done_i, which covers the state register and the frame-done step. Descriptor reads come from a bench memory model with an adjustable response latency, and each returned address is logged. Fetch order is checked from that log only after a fixed settle window.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_BASE,
    ST_FETCH_LINK,
    ST_WAIT_SOF,
    ST_XFER,
    ST_FRAME_END
  } seq_state_e;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/fbd_desc_regs.sv
module fbd_desc_regs #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_first_i,
  input  logic              load_link_i,
  input  logic              cap_base_i,
  input  logic              cap_link_i,
  input  logic              sel_link_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam logic [ADDR_W-1:0] LINK_OFS = ADDR_W'(fbd_pkg::WORD_BYTES);

  logic [ADDR_W-1:0] ptr_q, base_q, link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      base_q <= '0;
      link_q <= '0;
    end else begin
      if (load_first_i)     ptr_q <= first_i;
      else if (load_link_i) ptr_q <= link_q;
      if (cap_base_i) base_q <= rd_data_i;
      if (cap_link_i) link_q <= rd_data_i;
    end
  end

  assign rd_addr_o = sel_link_i ? ptr_q + LINK_OFS : ptr_q;
  assign base_o    = base_q;
endmodule

// File: rtl/fbd_wptr.sv
module fbd_wptr #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BURST_BEATS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BEATS * fbd_pkg::WORD_BYTES);

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (start_i)               busy_q <= 1'b1;
      else if (done_i && busy_q) busy_q <= 1'b0;
      if (init_i)                addr_q <= base_i;
      else if (done_i && busy_q) addr_q <= addr_q + STEP;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/fbd_ctrl.sv
module fbd_ctrl
  import fbd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rd_valid_i,
  input  logic frame_start_i,
  input  logic frame_end_i,
  input  logic fifo_thr_i,
  input  logic busy_i,
  output logic load_first_o,
  output logic load_link_o,
  output logic cap_base_o,
  output logic cap_link_o,
  output logic wptr_init_o,
  output logic burst_start_o,
  output logic rd_req_o,
  output logic sel_link_o
);
  seq_state_e st_q, st_d;
  logic sof_pend_q, eof_pend_q;
  logic sof_seen, eof_seen, in_fetch;

  assign in_fetch = (st_q == ST_FETCH_BASE) || (st_q == ST_FETCH_LINK);
  assign sof_seen = sof_pend_q | frame_start_i;
  assign eof_seen = eof_pend_q | frame_end_i;

  always_comb begin
    st_d          = st_q;
    load_first_o  = 1'b0;
    load_link_o   = 1'b0;
    cap_base_o    = 1'b0;
    cap_link_o    = 1'b0;
    wptr_init_o   = 1'b0;
    burst_start_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (en_i) begin
        st_d         = ST_FETCH_BASE;
        load_first_o = 1'b1;
      end
      ST_FETCH_BASE: if (rd_valid_i) begin
        cap_base_o = 1'b1;
        st_d       = en_i ? ST_FETCH_LINK : ST_IDLE;
      end
      ST_FETCH_LINK: if (rd_valid_i) begin
        cap_link_o = 1'b1;
        if (!en_i) st_d = ST_IDLE;
        else if (sof_seen) begin
          st_d        = ST_XFER;
          wptr_init_o = 1'b1;
        end else st_d = ST_WAIT_SOF;
      end
      ST_WAIT_SOF: begin
        if (!en_i) st_d = ST_IDLE;
        else if (frame_start_i) begin
          st_d        = ST_XFER;
          wptr_init_o = 1'b1;
        end
      end
      ST_XFER: if (!busy_i) begin
        if (eof_seen)        st_d = ST_FRAME_END;
        else if (!en_i)      st_d = ST_IDLE;
        else if (fifo_thr_i) burst_start_o = 1'b1;
      end
      ST_FRAME_END: begin
        load_link_o = 1'b1;
        st_d        = en_i ? ST_FETCH_BASE : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sof_pend_q <= 1'b0;
      eof_pend_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      // start strobes are only remembered across a pending fetch
      sof_pend_q <= in_fetch ? sof_seen : 1'b0;
      eof_pend_q <= (st_q == ST_XFER) ? eof_seen : 1'b0;
    end
  end

  assign rd_req_o   = in_fetch;
  assign sel_link_o = (st_q == ST_FETCH_LINK);
endmodule

// File: rtl/fbd_dma_seq.sv
module fbd_dma_seq #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BURST_BEATS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] first_desc_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_data_i,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic              fifo_thr_i,
  output logic              burst_req_o,
  output logic [ADDR_W-1:0] burst_addr_o,
  input  logic              burst_done_i
);
  logic load_first, load_link, cap_base, cap_link, wptr_init, burst_start, sel_link, busy;
  logic [ADDR_W-1:0] base;

  fbd_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .rd_valid_i    (rd_valid_i),
    .frame_start_i (frame_start_i),
    .frame_end_i   (frame_end_i),
    .fifo_thr_i    (fifo_thr_i),
    .busy_i        (busy),
    .load_first_o  (load_first),
    .load_link_o   (load_link),
    .cap_base_o    (cap_base),
    .cap_link_o    (cap_link),
    .wptr_init_o   (wptr_init),
    .burst_start_o (burst_start),
    .rd_req_o      (rd_req_o),
    .sel_link_o    (sel_link)
  );

  fbd_desc_regs #(.ADDR_W(ADDR_W)) u_desc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_first_i (load_first),
    .load_link_i  (load_link),
    .cap_base_i   (cap_base),
    .cap_link_i   (cap_link),
    .sel_link_i   (sel_link),
    .first_i      (first_desc_i),
    .rd_data_i    (rd_data_i),
    .rd_addr_o    (rd_addr_o),
    .base_o       (base)
  );

  fbd_wptr #(.ADDR_W(ADDR_W), .BURST_BEATS(BURST_BEATS)) u_wptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (wptr_init),
    .start_i (burst_start),
    .done_i  (burst_done_i),
    .base_i  (base),
    .busy_o  (busy),
    .addr_o  (burst_addr_o)
  );

  assign burst_req_o = busy;
endmodule

// File: rtl/fbd_dma_seq_chk.sv
module fbd_dma_seq_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BURST_BEATS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              burst_req_o,
  input logic [ADDR_W-1:0] burst_addr_o,
  input logic              burst_done_i
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BEATS * 4);

  logic              seen_q;
  logic [ADDR_W-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      exp_q  <= '0;
    end else if (rd_req_o) begin
      seen_q <= 1'b0;
    end else if (burst_req_o && burst_done_i) begin
      seen_q <= 1'b1;
      exp_q  <= burst_addr_o + STEP;
    end
  end

  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_req_o && !burst_done_i |=> burst_req_o); // R4
  AST_BURST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_req_o && burst_done_i |=> !burst_req_o); // R4
  AST_BURST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_req_o && !burst_done_i |=> $stable(burst_addr_o)); // R3
  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_req_o) && seen_q |-> burst_addr_o == exp_q); // R3
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o)); // R10
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && burst_req_o)); // R10
endmodule

bind fbd_dma_seq fbd_dma_seq_chk #(.ADDR_W(ADDR_W), .BURST_BEATS(BURST_BEATS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .rd_valid_i   (rd_valid_i),
  .burst_req_o  (burst_req_o),
  .burst_addr_o (burst_addr_o),
  .burst_done_i (burst_done_i)
);

// File: tb/fbd_dma_seq_test.sv
`timescale 1ns/1ps
module fbd_dma_seq_test;
  localparam int unsigned AW    = 32;
  localparam int unsigned BEATS = 8;
  localparam logic [31:0] STEP  = 32'(BEATS * 4);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [AW-1:0] first_desc = '0;
  logic          rd_req, rd_valid = 1'b0;
  logic [AW-1:0] rd_addr, rd_data = '0;
  logic          sof = 1'b0, eof = 1'b0, thr = 1'b0, done = 1'b0;
  logic          burst_req;
  logic [AW-1:0] burst_addr;

  int n_chk = 0, n_fail = 0;
  int lat = 1, cnt = 0, rd_n = 0;
  logic [31:0] mem [16];
  logic [31:0] rd_log [64];

  always #5 clk = ~clk;

  fbd_dma_seq #(.ADDR_W(AW), .BURST_BEATS(BEATS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .first_desc_i(first_desc),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .frame_start_i(sof), .frame_end_i(eof), .fifo_thr_i(thr),
    .burst_req_o(burst_req), .burst_addr_o(burst_addr), .burst_done_i(done)
  );

  // descriptor memory model with adjustable latency
  always @(posedge clk) begin
    if (rd_valid) begin
      rd_valid <= 1'b0;
      cnt      <= 0;
    end else if (rd_req) begin
      if (cnt >= lat) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[rd_addr[5:2]];
        rd_log[rd_n % 64] = rd_addr;
        rd_n     <= rd_n + 1;
        cnt      <= 0;
      end else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_fetch();
    repeat (40) @(negedge clk);
  endtask

  task automatic chk_fetch(input logic [31:0] d, input string req);
    chk(rd_log[(rd_n - 2) % 64] == d, req, rd_log[(rd_n - 2) % 64], d);
    chk(rd_log[(rd_n - 1) % 64] == d + 4, req, rd_log[(rd_n - 1) % 64], d + 4);
  endtask

  task automatic do_burst(input logic [31:0] exp_addr, input string req);
    @(negedge clk) thr = 1'b1;
    @(negedge clk) thr = 1'b0;
    chk(burst_req == 1'b1, "R4 rise", 32'(burst_req), 32'd1);
    chk(burst_addr == exp_addr, req, burst_addr, exp_addr);
    @(negedge clk);
    @(negedge clk);
    chk(burst_req == 1'b1, "R4 hold", 32'(burst_req), 32'd1);
    done = 1'b1;
    @(negedge clk) done = 1'b0;
    chk(burst_req == 1'b0, "R4 drop", 32'(burst_req), 32'd0);
  endtask

  task automatic run_frame(input logic [31:0] base, input int nb, input bit send_sof, input string req);
    if (send_sof) begin
      @(negedge clk) sof = 1'b1;
      @(negedge clk) sof = 1'b0;
    end
    for (int k = 0; k < nb; k++) do_burst(base + STEP * 32'(k), req);
  endtask

  task automatic end_frame();
    @(negedge clk) eof = 1'b1;
    @(negedge clk) eof = 1'b0;
  endtask

  task automatic t_reset();
    #3;
    chk(rd_req == 1'b0 && burst_req == 1'b0, "R1 in reset", {rd_req, burst_req}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_req == 1'b0 && burst_req == 1'b0, "R1 after release", {rd_req, burst_req}, 0);
  endtask

  task automatic t_enable();
    first_desc = 32'h0;
    en = 1'b1;
    @(negedge clk);
    chk(rd_req == 1'b1, "R2 req", 32'(rd_req), 1);
    chk(rd_addr == 32'h0, "R2 addr", rd_addr, 0);
    wait_fetch();
    chk_fetch(32'h0, "R2 order");
  endtask

  task automatic t_idle_thr();
    bit seen = 0;
    thr = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (burst_req) seen = 1;
    end
    thr = 1'b0;
    chk(!seen, "R5 no burst before start", 32'(seen), 0);
  endtask

  task automatic t_early_sof();
    bit held = 1;
    lat = 6;
    end_frame();
    @(negedge clk);
    @(negedge clk) sof = 1'b1;
    @(negedge clk) sof = 1'b0;
    chk(rd_req == 1'b1 && rd_addr == 32'h0, "R10 fetch held", rd_addr, 0);
    thr = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (burst_req) held = 0;
    end
    thr = 1'b0;
    chk(held, "R5 no burst during fetch", 32'(held), 1);
    wait_fetch();
    chk_fetch(32'h0, "R6 ping-pong wrap");
    lat = 1;
    run_frame(32'h0002_A000, 1, 0, "R7 start held across fetch");
    end_frame();
    wait_fetch();
    chk_fetch(32'h10, "R6 next after held frame");
  endtask

  task automatic t_end_in_burst();
    run_frame(32'h0, 0, 1, "R8");
    @(negedge clk) thr = 1'b1;
    @(negedge clk) thr = 1'b0;
    chk(burst_req == 1'b1 && burst_addr == 32'h0003_A000, "R8 burst", burst_addr, 32'h0003_A000);
    eof = 1'b1;
    @(negedge clk) eof = 1'b0;
    chk(burst_req == 1'b1, "R8 burst survives end", 32'(burst_req), 1);
    done = 1'b1;
    @(negedge clk) done = 1'b0;
    chk(rd_req == 1'b0, "R8 no fetch yet", 32'(rd_req), 0);
    @(negedge clk);
    @(negedge clk);
    chk(rd_req == 1'b1 && rd_addr == 32'h20, "R8 fetch three cycles after done", rd_addr, 32'h20);
    wait_fetch();
    chk_fetch(32'h20, "R6 triple ring third");
    run_frame(32'h0005_0000, 1, 1, "R3 third buffer");
    end_frame();
    wait_fetch();
    chk_fetch(32'h0, "R6 triple wrap");
  endtask

  task automatic t_disable();
    bit quiet = 1;
    run_frame(32'h0, 0, 1, "R9");
    @(negedge clk) thr = 1'b1;
    @(negedge clk) thr = 1'b0;
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(burst_req == 1'b1, "R9 burst finishes", 32'(burst_req), 1);
    done = 1'b1;
    @(negedge clk) done = 1'b0;
    chk(burst_req == 1'b0, "R9 burst dropped", 32'(burst_req), 0);
    thr = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (burst_req || rd_req) quiet = 0;
    end
    thr = 1'b0;
    chk(quiet, "R9 idle after disable", 32'(quiet), 1);
    first_desc = 32'h10;
    en = 1'b1;
    @(negedge clk);
    chk(rd_req == 1'b1 && rd_addr == 32'h10, "R9 restart at first desc", rd_addr, 32'h10);
    wait_fetch();
    chk_fetch(32'h10, "R9 restart order");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    for (int i = 0; i < 64; i++) rd_log[i] = 32'hFFFF_FFFF;
    mem[0] = 32'h0002_A000; mem[1] = 32'h10;
    mem[4] = 32'h0003_A000; mem[5] = 32'h00;
    mem[8] = 32'h0005_0000; mem[9] = 32'h00;
    t_reset();
    t_enable();
    t_idle_thr();
    run_frame(32'h0002_A000, 3, 1, "R3 buffer A");
    end_frame();
    wait_fetch();
    chk_fetch(32'h10, "R6 link followed");
    run_frame(32'h0003_A000, 2, 1, "R3 buffer B");
    mem[5] = 32'h20;
    t_early_sof();
    t_end_in_burst();
    t_disable();
    report();
  end
endmodule